// File: doc/BRIEF.md
# Mux-Scan Registered Boolean Core

This block is a small registered logic cell made testable by full scan. Three functional inputs are each captured in their own flip-flop. A combinational core computes Z = (not A and B) or (B and C) from those registered values, and a fourth flip-flop registers the result onto the functional output. Each of the four flip-flops is a scan cell: a D flip-flop whose D input passes through a two-way selector. One leg of the selector carries functional data. The other leg carries the output of the previous cell in the chain.

A single mode input switches all four cells at the same time. With the mode input low, the block is plain registered logic. With it high, the cells form a four-stage shift register from the serial input to the serial output. An external tester uses this path in three steps. It shifts a pattern in over four cycles. It then lowers the mode input for one capture edge. Finally it shifts the response out over four more cycles and compares it against the Boolean function.

Top module: `scan_core_top`

## Requirements
- R1: A synchronous active-high reset clears all four flip-flops to 0 whatever the level of scan_en, so z_out and scan_out read 0 after the reset edge.
- R2: With scan_en low, every clock edge loads in_a, in_b and in_c into the A, B and C flip-flops.
- R3: With scan_en low, every clock edge loads the Z flip-flop with (not A and B) or (B and C) of the registered A, B and C values. A functional input pattern therefore appears on z_out two edges after it is applied.
- R4: With scan_en high, the chain order is A, B, C, Z. The A flip-flop takes scan_in, B takes A, C takes B, and Z takes C instead of the core result.
- R5: scan_out is driven from the Z flip-flop and always equals z_out.
- R6: Shifting a bit from scan_in to scan_out takes exactly four consecutive shift edges, which is one edge per flip-flop in the chain.
- R7: While scan_en is high, in_a, in_b and in_c have no effect on the shifted data.
- R8: After a pattern is loaded, one edge with scan_en low has two effects. The Z flip-flop captures the function of the loaded A, B and C values. The A, B and C flip-flops capture the input ports. The following unload presents Z first, then C, then B, then A on scan_out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all flip-flops |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | 1 = shift mode, 0 = functional or capture mode |
| scan_in | input | 1 | Serial test data into the A flip-flop |
| in_a | input | 1 | Functional input A |
| in_b | input | 1 | Functional input B |
| in_c | input | 1 | Functional input C |
| z_out | output | 1 | Registered functional result Z |
| scan_out | output | 1 | Serial test data out of the Z flip-flop |

## Verification
A wrong bit in any of the four flip-flops is visible at the ports within at most four shift edges. A stuck or misordered cell shifts the wrong value out, and the position of that value in the unload tells which cell is at fault. A Z flip-flop that loads the core result during shift, or a core that computes the wrong function, shows up on the first unloaded bit directly after the capture edge. In functional mode, an error in an input flip-flop reaches z_out two edges after the input pattern is applied.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int NUM_IN    = 3;
  localparam int CHAIN_LEN = NUM_IN + 1;
  localparam int RUN_W     = $clog2(CHAIN_LEN + 1);

  function automatic logic core_fn(input logic a, input logic b, input logic c);
    return (~a & b) | (b & c);
  endfunction
endpackage

// File: rtl/scan_cell.sv
module scan_cell (
  input  logic clk,
  input  logic rst,
  input  logic sel_shift,
  input  logic func_d,
  input  logic chain_d,
  output logic q
);
  logic d_mux;

  always_comb d_mux = sel_shift ? chain_d : func_d;

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d_mux;
  end
endmodule

// File: rtl/bool_core.sv
module bool_core (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic z
);
  import scan_pkg::*;
  always_comb z = core_fn(a, b, c);
endmodule

// File: rtl/scan_core_top.sv
module scan_core_top (
  input  logic clk,
  input  logic rst,
  input  logic scan_en,
  input  logic scan_in,
  input  logic in_a,
  input  logic in_b,
  input  logic in_c,
  output logic z_out,
  output logic scan_out
);
  import scan_pkg::*;

  logic [NUM_IN-1:0] in_vec;
  logic [NUM_IN-1:0] in_q;
  logic [NUM_IN-1:0] link;
  logic              core_z;
  logic              z_q;

  assign in_vec = {in_c, in_b, in_a};

  genvar i;
  generate
    for (i = 0; i < NUM_IN; i++) begin : g_in_cell
      if (i == 0) begin : g_head
        assign link[i] = scan_in;
      end else begin : g_mid
        assign link[i] = in_q[i-1];
      end
      scan_cell u_cell (
        .clk      (clk),
        .rst      (rst),
        .sel_shift(scan_en),
        .func_d   (in_vec[i]),
        .chain_d  (link[i]),
        .q        (in_q[i])
      );
    end
  endgenerate

  bool_core u_core (
    .a(in_q[0]),
    .b(in_q[1]),
    .c(in_q[2]),
    .z(core_z)
  );

  scan_cell u_zcell (
    .clk      (clk),
    .rst      (rst),
    .sel_shift(scan_en),
    .func_d   (core_z),
    .chain_d  (in_q[NUM_IN-1]),
    .q        (z_q)
  );

  assign z_out    = z_q;
  assign scan_out = z_q;

  // consecutive shift edges seen since reset or last capture
  logic [RUN_W-1:0] shift_run;
  always_ff @(posedge clk) begin
    if (rst || !scan_en)                shift_run <= '0;
    else if (shift_run < RUN_W'(CHAIN_LEN)) shift_run <= shift_run + 1'b1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (z_q == 1'b0 && in_q == '0));

  // R3
  func_z_chk: assert property (@(posedge clk) disable iff (rst)
    (!scan_en && !$past(scan_en) && !$past(rst)) |=>
      z_out == core_fn($past(in_a, 2), $past(in_b, 2), $past(in_c, 2)));

  // R4
  chain_order_chk: assert property (@(posedge clk) disable iff (rst)
    scan_en |=> (z_q == $past(in_q[2]) && in_q[1] == $past(in_q[0])));

  // R6
  shift_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (shift_run >= RUN_W'(CHAIN_LEN)) |-> scan_out == $past(scan_in, CHAIN_LEN));
endmodule

// File: tb/scan_core_top_tb.sv
module scan_core_top_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scan_en = 1'b1;
  logic scan_in = 1'b1;
  logic in_a = 1'b0, in_b = 1'b0, in_c = 1'b0;
  logic z_out, scan_out;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  scan_core_top u_dut (
    .clk(clk), .rst(rst), .scan_en(scan_en), .scan_in(scan_in),
    .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .z_out(z_out), .scan_out(scan_out)
  );

  // rows: {load_a, load_b, load_c, port_a, port_b, port_c, expected_z}
  localparam logic [6:0] VEC [8] = '{
    7'b000_111_0, 7'b001_110_0, 7'b010_101_1, 7'b011_100_1,
    7'b100_011_0, 7'b101_010_0, 7'b110_001_0, 7'b111_000_1
  };

  function automatic logic ref_z(input logic [2:0] abc);
    return (~abc[2] & abc[1]) | (abc[1] & abc[0]);
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    // R1: reset held with scan_en high still clears
    repeat (3) step();
    rst = 1'b0;
    check("R1 z_out", z_out, 1'b0);
    check("R1 scan_out", scan_out, 1'b0);
    // R6: ones enter; first reaches scan_out on the 4th shift edge
    for (int k = 1; k <= 4; k++) begin
      step();
      check(k == 4 ? "R6 arrival" : "R1 cleared cell", scan_out, k == 4);
    end

    // R2 R3: functional stream, z two edges after the pattern
    scan_en = 1'b0;
    for (int i = 0; i < 10; i++) begin
      logic [2:0] cur;
      cur = 3'(i % 8);
      {in_a, in_b, in_c} = cur;
      step();
      if (i >= 1) check("R3 functional z", z_out, ref_z(3'((i - 1) % 8)));
    end
    // R2: inputs held, then unload shows C, B, A of the last pattern
    {in_a, in_b, in_c} = 3'b101;
    step();
    scan_en = 1'b1; scan_in = 1'b0;
    step(); check("R2 C flop", scan_out, 1'b1);
    step(); check("R2 B flop", scan_out, 1'b0);
    step(); check("R2 A flop", scan_out, 1'b1);

    // R4 R7 R8: load, capture, unload per table row
    for (int r = 0; r < 8; r++) begin
      logic [6:0] v;
      logic [3:0] stream;
      v = VEC[r];
      stream = {~v[0], v[4], v[5], v[6]}; // Z seed first, A last
      scan_en = 1'b1;
      for (int s = 3; s >= 0; s--) begin
        scan_in = stream[s];
        {in_a, in_b, in_c} = 3'(s + r); // junk during shift, R7
        step();
      end
      check("R4 R7 Z seed", scan_out, ~v[0]);
      scan_en = 1'b0;
      {in_a, in_b, in_c} = v[3:1];
      step();
      check("R8 captured z", z_out, v[0]);
      check("R5 scan_out equals z_out", scan_out, z_out);
      scan_en = 1'b1; scan_in = 1'b0;
      step(); check("R8 unload C", scan_out, v[1]);
      step(); check("R8 unload B", scan_out, v[2]);
      step(); check("R8 unload A", scan_out, v[3]);
    end

    // R1: reset mid-shift with data in chain
    scan_in = 1'b1;
    repeat (3) step();
    rst = 1'b1;
    step();
    rst = 1'b0;
    check("R1 mid-shift reset", scan_out, 1'b0);
    step(); check("R1 C cleared", scan_out, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule